// File: doc/BRIEF.md
# FIFO Level Event, DMA Request and Interrupt Controller

This block watches a transmit FIFO and a receive FIFO from the side and turns their fill levels and access events into DMA requests, sticky interrupt flags and sticky wake flags. It compares the transmit fill count against a programmed level and requests more data while the count is below that level. It compares the receive fill count against its own level and requests draining while the count is above it. Four access errors are latched: a push into a full FIFO or a pop from an empty one, from either the bus side or the serial side.

Software clears flags by writing ones to them. The block can also be told to flush a FIFO, which gives the FIFO a one-cycle pointer-reset strobe and drops every pending condition for that side. A single interrupt line and a single wake line combine the flags with their per-flag enables. The FIFO storage and the register decoding live outside this block.

Top module: `fifo_evt_ctrl`

## Requirements
- R1: Out of reset, every flag, both DMA requests, both pointer-reset strobes, the interrupt line and the wake line are 0.
- R2: One cycle after the transmit DMA enable is high and the transmit count is strictly below the transmit level, the transmit DMA request is 1. When the count equals or exceeds the level, it is 0 one cycle later.
- R3: One cycle after the receive DMA enable is high and the receive count is strictly above the receive level, the receive DMA request is 1. When the count equals or is below the level, it is 0 one cycle later.
- R4: One cycle after a direction's DMA enable is low, that direction's request is 0, whatever the count.
- R5: Interrupt flag bit 0 latches the transmit below-level condition, bit 1 the transmit-empty input, bit 2 the receive above-level condition and bit 3 the receive-full input. Each takes effect one cycle later.
- R6: Flag bit 4 latches a bus push while the transmit FIFO is full, and bit 5 a serial pop while it is empty. Bit 6 latches a serial push while the receive FIFO is full, and bit 7 a bus pop while it is empty. A push into a FIFO that is not full sets nothing.
- R7: A write strobe with a data mask clears, one cycle later, each flag whose mask bit is 1. Flags whose mask bit is 0 are untouched.
- R8: When a set event and a write-one clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: A transmit flush pulses the transmit pointer-reset for one cycle. It clears interrupt bits 0, 1, 4 and 5, wake bits 0 and 1, and the transmit DMA request, overriding any set in that cycle. A receive flush does the same for its own side: interrupt bits 2, 3, 6 and 7, wake bits 2 and 3, and the receive request.
- R10: The interrupt line is 1 exactly when some interrupt flag and its enable bit are both 1.
- R11: Wake flag bits 0 to 3 latch the same four conditions as interrupt bits 0 to 3. They have their own write-one clear, and the wake line is 1 exactly when some wake flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txCount | input | LVL_W | Transmit FIFO fill count |
| rxCount | input | LVL_W | Receive FIFO fill count |
| txLevel | input | LVL_W | Transmit request level |
| rxLevel | input | LVL_W | Receive request level |
| txFull | input | 1 | Transmit FIFO full |
| txEmpty | input | 1 | Transmit FIFO empty |
| rxFull | input | 1 | Receive FIFO full |
| rxEmpty | input | 1 | Receive FIFO empty |
| busPush | input | 1 | Bus-side push attempt into transmit FIFO |
| busPop | input | 1 | Bus-side pop attempt from receive FIFO |
| serPush | input | 1 | Serial-side push attempt into receive FIFO |
| serPop | input | 1 | Serial-side pop attempt from transmit FIFO |
| txDmaEn | input | 1 | Transmit DMA enable |
| rxDmaEn | input | 1 | Receive DMA enable |
| txClear | input | 1 | Transmit flush command |
| rxClear | input | 1 | Receive flush command |
| irqEn | input | 8 | Per-flag interrupt enables |
| wakeEn | input | 4 | Per-flag wake enables |
| irqClrWr | input | 1 | Write-one-clear strobe for interrupt flags |
| irqClrData | input | 8 | Clear mask for interrupt flags |
| wakeClrWr | input | 1 | Write-one-clear strobe for wake flags |
| wakeClrData | input | 4 | Clear mask for wake flags |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txPtrReset | output | 1 | Transmit FIFO pointer-reset strobe |
| rxPtrReset | output | 1 | Receive FIFO pointer-reset strobe |
| irqFlags | output | 8 | Sticky interrupt flags |
| wakeFlags | output | 4 | Sticky wake flags |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Combined wake |

## Verification
A flag can be set by its event and cleared by software in the same cycle. The bench provokes this by holding a bus push into a full transmit FIFO while it writes a clear mask with bit 4 set, and it expects bit 4 to read 1 afterwards. A flush and a set for the same side can also coincide. The bench drives a transmit flush together with a below-level count, an overrun push and an active DMA enable, and it expects every transmit-side flag and the request to read 0 while the receive-side flags keep their values.

// File: rtl/fifo_evt_pkg.sv
package fifo_evt_pkg;
  localparam int NUM_IRQ  = 8;
  localparam int NUM_WAKE = 4;

  // interrupt flag positions
  localparam int F_TX_LOW   = 0;
  localparam int F_TX_EMPTY = 1;
  localparam int F_RX_HIGH  = 2;
  localparam int F_RX_FULL  = 3;
  localparam int F_TX_OVR   = 4;
  localparam int F_TX_UND   = 5;
  localparam int F_RX_OVR   = 6;
  localparam int F_RX_UND   = 7;

  localparam logic [NUM_IRQ-1:0]  TX_IRQ_MASK  = 8'b0011_0011;
  localparam logic [NUM_IRQ-1:0]  RX_IRQ_MASK  = 8'b1100_1100;
  localparam logic [NUM_WAKE-1:0] TX_WAKE_MASK = 4'b0011;
  localparam logic [NUM_WAKE-1:0] RX_WAKE_MASK = 4'b1100;

  typedef struct packed {
    logic [NUM_IRQ-1:0]  irqSet;
    logic [NUM_WAKE-1:0] wakeSet;
    logic                txReqCond;
    logic                rxReqCond;
    logic                txFlush;
    logic                rxFlush;
  } evt_strobe_t;
endpackage

// File: rtl/fifo_evt_control.sv
module fifo_evt_control import fifo_evt_pkg::*; #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] txCount,
  input  logic [LVL_W-1:0] rxCount,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  input  logic             busPush,
  input  logic             busPop,
  input  logic             serPush,
  input  logic             serPop,
  input  logic             txDmaEn,
  input  logic             rxDmaEn,
  input  logic             txClear,
  input  logic             rxClear,
  output evt_strobe_t      strb
);
  logic txBelow;
  logic rxAbove;

  assign txBelow = txCount < txLevel;
  assign rxAbove = rxCount > rxLevel;

  always_comb begin
    strb = '0;
    strb.irqSet[F_TX_LOW]   = txBelow;
    strb.irqSet[F_TX_EMPTY] = txEmpty;
    strb.irqSet[F_RX_HIGH]  = rxAbove;
    strb.irqSet[F_RX_FULL]  = rxFull;
    strb.irqSet[F_TX_OVR]   = busPush & txFull;
    strb.irqSet[F_TX_UND]   = serPop  & txEmpty;
    strb.irqSet[F_RX_OVR]   = serPush & rxFull;
    strb.irqSet[F_RX_UND]   = busPop  & rxEmpty;
    strb.wakeSet            = strb.irqSet[NUM_WAKE-1:0];
    strb.txReqCond          = txDmaEn & txBelow;
    strb.rxReqCond          = rxDmaEn & rxAbove;
    strb.txFlush            = txClear;
    strb.rxFlush            = rxClear;
  end
endmodule

// File: rtl/fifo_evt_datapath.sv
module fifo_evt_datapath import fifo_evt_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  evt_strobe_t         strb,
  input  logic [NUM_IRQ-1:0]  irqEn,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic                irqClrWr,
  input  logic [NUM_IRQ-1:0]  irqClrData,
  input  logic                wakeClrWr,
  input  logic [NUM_WAKE-1:0] wakeClrData,
  output logic                txDmaReq,
  output logic                rxDmaReq,
  output logic                txPtrReset,
  output logic                rxPtrReset,
  output logic [NUM_IRQ-1:0]  irqFlags,
  output logic [NUM_WAKE-1:0] wakeFlags,
  output logic                irq,
  output logic                wake
);
  logic [NUM_IRQ-1:0]  irqFlush;
  logic [NUM_WAKE-1:0] wakeFlush;

  assign irqFlush  = (strb.txFlush ? TX_IRQ_MASK  : '0) | (strb.rxFlush ? RX_IRQ_MASK  : '0);
  assign wakeFlush = (strb.txFlush ? TX_WAKE_MASK : '0) | (strb.rxFlush ? RX_WAKE_MASK : '0);

  // flush beats set, set beats write-one clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irqFlag
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           bitQ <= 1'b0;
      else if (irqFlush[i])                bitQ <= 1'b0;
      else if (strb.irqSet[i])             bitQ <= 1'b1;
      else if (irqClrWr && irqClrData[i])  bitQ <= 1'b0;
    end
    assign irqFlags[i] = bitQ;
  end

  for (genvar j = 0; j < NUM_WAKE; j++) begin : g_wakeFlag
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            bitQ <= 1'b0;
      else if (wakeFlush[j])                bitQ <= 1'b0;
      else if (strb.wakeSet[j])             bitQ <= 1'b1;
      else if (wakeClrWr && wakeClrData[j]) bitQ <= 1'b0;
    end
    assign wakeFlags[j] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDmaReq   <= 1'b0;
      rxDmaReq   <= 1'b0;
      txPtrReset <= 1'b0;
      rxPtrReset <= 1'b0;
    end else begin
      txDmaReq   <= strb.txReqCond & ~strb.txFlush;
      rxDmaReq   <= strb.rxReqCond & ~strb.rxFlush;
      txPtrReset <= strb.txFlush;
      rxPtrReset <= strb.rxFlush;
    end
  end

  assign irq  = |(irqFlags & irqEn);
  assign wake = |(wakeFlags & wakeEn);
endmodule

// File: rtl/fifo_evt_ctrl.sv
module fifo_evt_ctrl import fifo_evt_pkg::*; #(
  parameter int LVL_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LVL_W-1:0]    txCount,
  input  logic [LVL_W-1:0]    rxCount,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  input  logic                txFull,
  input  logic                txEmpty,
  input  logic                rxFull,
  input  logic                rxEmpty,
  input  logic                busPush,
  input  logic                busPop,
  input  logic                serPush,
  input  logic                serPop,
  input  logic                txDmaEn,
  input  logic                rxDmaEn,
  input  logic                txClear,
  input  logic                rxClear,
  input  logic [NUM_IRQ-1:0]  irqEn,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic                irqClrWr,
  input  logic [NUM_IRQ-1:0]  irqClrData,
  input  logic                wakeClrWr,
  input  logic [NUM_WAKE-1:0] wakeClrData,
  output logic                txDmaReq,
  output logic                rxDmaReq,
  output logic                txPtrReset,
  output logic                rxPtrReset,
  output logic [NUM_IRQ-1:0]  irqFlags,
  output logic [NUM_WAKE-1:0] wakeFlags,
  output logic                irq,
  output logic                wake
);
  evt_strobe_t strb;

  fifo_evt_control #(.LVL_W(LVL_W)) ctrl_i (
    .txCount(txCount), .rxCount(rxCount), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .busPush(busPush), .busPop(busPop), .serPush(serPush), .serPop(serPop),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .txClear(txClear), .rxClear(rxClear),
    .strb(strb)
  );

  fifo_evt_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .irqEn(irqEn), .wakeEn(wakeEn),
    .irqClrWr(irqClrWr), .irqClrData(irqClrData),
    .wakeClrWr(wakeClrWr), .wakeClrData(wakeClrData),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txPtrReset(txPtrReset), .rxPtrReset(rxPtrReset),
    .irqFlags(irqFlags), .wakeFlags(wakeFlags), .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/fifo_evt_checker.sv
module fifo_evt_checker import fifo_evt_pkg::*; #(
  parameter int LVL_W = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [LVL_W-1:0]    txCount,
  input logic [LVL_W-1:0]    rxCount,
  input logic [LVL_W-1:0]    txLevel,
  input logic [LVL_W-1:0]    rxLevel,
  input logic                txFull,
  input logic                txEmpty,
  input logic                rxFull,
  input logic                rxEmpty,
  input logic                busPush,
  input logic                busPop,
  input logic                serPush,
  input logic                serPop,
  input logic                txDmaEn,
  input logic                rxDmaEn,
  input logic                txClear,
  input logic                rxClear,
  input logic [NUM_IRQ-1:0]  irqEn,
  input logic [NUM_WAKE-1:0] wakeEn,
  input logic                irqClrWr,
  input logic [NUM_IRQ-1:0]  irqClrData,
  input logic                txDmaReq,
  input logic                rxDmaReq,
  input logic                txPtrReset,
  input logic [NUM_IRQ-1:0]  irqFlags,
  input logic [NUM_WAKE-1:0] wakeFlags,
  input logic                irq,
  input logic                wake
);
  p_tx_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txDmaEn && (txCount < txLevel) && !txClear) |=> txDmaReq);

  p_rx_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxDmaEn && (rxCount > rxLevel) && !rxClear) |=> rxDmaReq);

  p_tx_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !txDmaEn |=> !txDmaReq);

  p_rx_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxDmaEn |=> !rxDmaReq);

  p_tx_ovr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busPush && txFull && !txClear) |=> irqFlags[F_TX_OVR]);

  p_clr_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqClrWr && irqClrData[F_RX_UND] && !(busPop && rxEmpty)) |=> !irqFlags[F_RX_UND]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (serPush && rxFull && !rxClear && irqClrWr && irqClrData[F_RX_OVR]) |=> irqFlags[F_RX_OVR]);

  p_tx_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    txClear |=> (txPtrReset && !txDmaReq && ((irqFlags & TX_IRQ_MASK) == '0)
                 && ((wakeFlags & TX_WAKE_MASK) == '0)));

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((irqFlags & irqEn) != '0));

  p_wake_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> ((wakeFlags & wakeEn) != '0));
endmodule

bind fifo_evt_ctrl fifo_evt_checker #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
  .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull), .txEmpty(txEmpty),
  .rxFull(rxFull), .rxEmpty(rxEmpty), .busPush(busPush), .busPop(busPop),
  .serPush(serPush), .serPop(serPop), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
  .txClear(txClear), .rxClear(rxClear), .irqEn(irqEn), .wakeEn(wakeEn),
  .irqClrWr(irqClrWr), .irqClrData(irqClrData), .txDmaReq(txDmaReq),
  .rxDmaReq(rxDmaReq), .txPtrReset(txPtrReset), .irqFlags(irqFlags),
  .wakeFlags(wakeFlags), .irq(irq), .wake(wake)
);

// File: tb/fifo_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_evt_ctrl_tb_top;
  import fifo_evt_pkg::*;
  localparam int LVL_W = 6;

  typedef struct packed {
    logic [LVL_W-1:0] txCount, rxCount, txLevel, rxLevel;
    logic txFull, txEmpty, rxFull, rxEmpty;
    logic busPush, busPop, serPush, serPop;
    logic txDmaEn, rxDmaEn, txClear, rxClear;
    logic [7:0] irqEn;
    logic [3:0] wakeEn;
    logic irqClrWr;
    logic [7:0] irqClrData;
    logic wakeClrWr;
    logic [3:0] wakeClrData;
  } stim_t;

  typedef struct packed {
    logic txReq, rxReq, txPtr, rxPtr;
    logic [7:0] flags;
    logic [3:0] wflags;
    logic irqO, wakeO;
  } obs_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LVL_W-1:0] txCount, rxCount, txLevel, rxLevel;
  logic txFull, txEmpty, rxFull, rxEmpty, busPush, busPop, serPush, serPop;
  logic txDmaEn, rxDmaEn, txClear, rxClear, irqClrWr, wakeClrWr;
  logic [7:0] irqEn, irqClrData;
  logic [3:0] wakeEn, wakeClrData;
  logic txDmaReq, rxDmaReq, txPtrReset, rxPtrReset, irq, wake;
  logic [7:0] irqFlags;
  logic [3:0] wakeFlags;

  int checks = 0;
  int errors = 0;
  obs_t  expQ[$];
  string tagQ[$];
  logic [7:0] mFlags = '0;
  logic [3:0] mWake  = '0;

  always #4 clk = ~clk;

  fifo_evt_ctrl #(.LVL_W(LVL_W)) dut_i (
    .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
    .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .busPush(busPush), .busPop(busPop),
    .serPush(serPush), .serPop(serPop), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .txClear(txClear), .rxClear(rxClear), .irqEn(irqEn), .wakeEn(wakeEn),
    .irqClrWr(irqClrWr), .irqClrData(irqClrData), .wakeClrWr(wakeClrWr),
    .wakeClrData(wakeClrData), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txPtrReset(txPtrReset), .rxPtrReset(rxPtrReset), .irqFlags(irqFlags),
    .wakeFlags(wakeFlags), .irq(irq), .wake(wake)
  );

  function automatic obs_t sampleOut();
    obs_t o;
    o.txReq = txDmaReq; o.rxReq = rxDmaReq; o.txPtr = txPtrReset; o.rxPtr = rxPtrReset;
    o.flags = irqFlags; o.wflags = wakeFlags; o.irqO = irq; o.wakeO = wake;
    return o;
  endfunction

  task automatic compare(input obs_t got, input obs_t exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual txReq=%b rxReq=%b txPtr=%b rxPtr=%b flags=%h wake=%h irq=%b wk=%b expected txReq=%b rxReq=%b txPtr=%b rxPtr=%b flags=%h wake=%h irq=%b wk=%b",
        tag, got.txReq, got.rxReq, got.txPtr, got.rxPtr, got.flags, got.wflags, got.irqO, got.wakeO,
        exp.txReq, exp.rxReq, exp.txPtr, exp.rxPtr, exp.flags, exp.wflags, exp.irqO, exp.wakeO);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the result the requirements predict
  task automatic step(input stim_t s, input string tag);
    logic [7:0] setB;
    logic [7:0] clrB;
    logic [3:0] wclrB;
    obs_t e;
    @(negedge clk);
    txCount = s.txCount; rxCount = s.rxCount; txLevel = s.txLevel; rxLevel = s.rxLevel;
    txFull = s.txFull; txEmpty = s.txEmpty; rxFull = s.rxFull; rxEmpty = s.rxEmpty;
    busPush = s.busPush; busPop = s.busPop; serPush = s.serPush; serPop = s.serPop;
    txDmaEn = s.txDmaEn; rxDmaEn = s.rxDmaEn; txClear = s.txClear; rxClear = s.rxClear;
    irqEn = s.irqEn; wakeEn = s.wakeEn; irqClrWr = s.irqClrWr; irqClrData = s.irqClrData;
    wakeClrWr = s.wakeClrWr; wakeClrData = s.wakeClrData;
    setB = {s.busPop & s.rxEmpty, s.serPush & s.rxFull, s.serPop & s.txEmpty,
            s.busPush & s.txFull, s.rxFull, s.rxCount > s.rxLevel, s.txEmpty,
            s.txCount < s.txLevel};
    clrB  = s.irqClrWr  ? s.irqClrData  : 8'h00;
    wclrB = s.wakeClrWr ? s.wakeClrData : 4'h0;
    mFlags = (mFlags & ~clrB) | setB;
    mWake  = (mWake & ~wclrB) | setB[3:0];
    if (s.txClear) begin mFlags = mFlags & 8'hCC; mWake = mWake & 4'hC; end
    if (s.rxClear) begin mFlags = mFlags & 8'h33; mWake = mWake & 4'h3; end
    e.txReq  = s.txDmaEn & setB[0] & ~s.txClear;
    e.rxReq  = s.rxDmaEn & setB[2] & ~s.rxClear;
    e.txPtr  = s.txClear;
    e.rxPtr  = s.rxClear;
    e.flags  = mFlags;
    e.wflags = mWake;
    e.irqO   = |(mFlags & s.irqEn);
    e.wakeO  = |(mWake & s.wakeEn);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: after each active edge, pops and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(sampleOut(), expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    stim_t s;
    obs_t zero;
    s = '0;
    zero = '0;
    {txCount, rxCount, txLevel, rxLevel} = '0;
    {txFull, txEmpty, rxFull, rxEmpty, busPush, busPop, serPush, serPop} = '0;
    {txDmaEn, rxDmaEn, txClear, rxClear, irqClrWr, wakeClrWr} = '0;
    irqEn = '0; irqClrData = '0; wakeEn = '0; wakeClrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(sampleOut(), zero, "R1 reset state");

    // R2 transmit request, below / equal / below
    s = '0; s.txLevel = 6'd8; s.txCount = 6'd3; s.txDmaEn = 1'b1; step(s, "R2 below level");
    s.txCount = 6'd8; step(s, "R2 equal level");
    s.txCount = 6'd7; step(s, "R2 one below level");
    // R4 enable removed
    s.txCount = 6'd3; s.txDmaEn = 1'b0; step(s, "R4 tx disable drops request");
    // R3 receive request
    s = '0; s.rxLevel = 6'd4; s.rxCount = 6'd5; s.rxDmaEn = 1'b1; step(s, "R3 above level");
    s.rxCount = 6'd4; step(s, "R3 equal level");
    s.rxCount = 6'd9; step(s, "R3 above again");
    s.rxDmaEn = 1'b0; step(s, "R4 rx disable drops request");
    // R5 empty and full flags
    s = '0; s.txEmpty = 1'b1; step(s, "R5 tx empty flag");
    s = '0; s.rxFull = 1'b1; step(s, "R5 rx full flag");
    // R7 partial then full clear
    s = '0; s.irqClrWr = 1'b1; s.irqClrData = 8'h05; step(s, "R7 clear bits 0 and 2");
    s.irqClrData = 8'h0A; step(s, "R7 clear bits 1 and 3");
    // R6 error events
    s = '0; s.busPush = 1'b1; step(s, "R6 push not full no flag");
    s.txFull = 1'b1; step(s, "R6 tx overrun");
    s = '0; s.serPop = 1'b1; s.txEmpty = 1'b1; step(s, "R6 tx underrun");
    s = '0; s.serPush = 1'b1; s.rxFull = 1'b1; step(s, "R6 rx overrun");
    s = '0; s.busPop = 1'b1; s.rxEmpty = 1'b1; step(s, "R6 rx underrun");
    s = '0; s.irqClrWr = 1'b1; s.irqClrData = 8'h0F; step(s, "R7 low bits cleared high kept");
    // R8 set against clear
    s = '0; s.busPush = 1'b1; s.txFull = 1'b1; s.irqClrWr = 1'b1; s.irqClrData = 8'h10;
    step(s, "R8 set wins over clear");
    // R10 enable gating
    s = '0; s.irqEn = 8'h10; step(s, "R10 enabled flag drives irq");
    s.irqEn = 8'h01; step(s, "R10 masked flag no irq");
    // R9 flushes
    s = '0; s.txLevel = 6'd5; s.txCount = 6'd2; s.txDmaEn = 1'b1; s.txEmpty = 1'b1;
    step(s, "R9 prepare tx flags");
    s.busPush = 1'b1; s.txFull = 1'b1; s.txClear = 1'b1; s.irqEn = 8'hFF;
    step(s, "R9 tx flush overrides set");
    s = '0; s.rxClear = 1'b1; s.irqEn = 8'hFF; step(s, "R9 rx flush");
    s = '0; step(s, "R9 strobes return low");
    // R11 wake path
    s = '0; s.rxLevel = 6'd1; s.rxCount = 6'd9; s.wakeEn = 4'h4; step(s, "R11 wake set");
    s = '0; s.wakeEn = 4'h4; s.wakeClrWr = 1'b1; s.wakeClrData = 4'h4; step(s, "R11 wake cleared");
    s = '0; s.wakeEn = 4'h2; s.txEmpty = 1'b1; step(s, "R11 other wake bit");
    s = '0; s.wakeEn = 4'h1; step(s, "R11 masked wake");

    s = '0; step(s, "R1 idle");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule